// File: doc/BRIEF.md
# Multicart Outer Bank Mixer

This block sits between a game cartridge's inner bank-switching logic and its ROM address lines. It keeps four outer configuration registers and a small 8 KiB character latch. It takes the bank numbers offered by one of two inner mapper modes and merges them with the outer registers through size masks. The result is a final bank number for each of four 8 KiB program windows and each of eight 1 KiB character windows.

Each mask is derived by shifting an all-ones constant by a 3-bit size field. One bit of the mask then decides whether the inner mapper drives banking at all, or whether fixed flat windows are used instead.

The block also decides where a CPU write to the upper half of the address space goes: to inner mode A, to inner mode B, or to the local character latch. A lock bit freezes the outer registers. A 2-bit menu value advances on every soft reset, and when it matches the top two bits of outer register 0, cartridge ROM reads are turned off.

Top module: `mcOuterBankMixer`

## Requirements
- R1: A write with address bits [15:12] equal to 5 stores the data in outer register selected by address bits [1:0]. The new value shows on the bank outputs in the cycle after the write.
- R2: While bit 5 of outer register 3 is 1, writes to the outer registers have no effect, including writes to register 3 itself.
- R3: The program mask is the low 5 bits of 0x7F shifted right by register 2 bits [2:0]. Each program window's bank is (inner value AND mask) OR (register 0 AND NOT mask). If mask bit 2 is 1, the windows are fed as follows:
  - window 0 (bits 7:0 of the program bus) takes the inner low bank;
  - window 1 takes the inner high bank;
  - window 2 takes 0xFE;
  - window 3 (bits 31:24) takes 0xFF.
- R4: With mask bit 2 set and the active inner mode's swap input high, the inner values of windows 0 and 2 are exchanged.
- R5: With program mask bit 2 clear, windows 0 to 3 take inner values 0, 1, 2 and 3.
- R6: The character mask is the low 8 bits of 0x3FF shifted right by register 2 bits [5:3]. If its bit 5 is 1, window i (bits 11i+10:11i) equals (inner value i AND mask) OR ((register 1 shifted left by 3) AND NOT mask), 11 bits wide.
- R7: If character mask bit 5 is 0, an 8 KiB bank is formed. It is (latch AND (mask >> 3)) OR (register 1 AND NOT (mask >> 3)). Window i then outputs that bank times 8 plus i.
- R8: A write with address bit 15 set goes to the latch when register 2 bits [5:3] are 5 or more. Otherwise it raises the inner strobe of the active mode for that cycle. At most one inner strobe is high, and only during such a write.
- R9: Register 3 bit 4 picks inner mode B (1) or A (0) as the source of the program banks, character banks and 2-bit mirroring output.
- R10: romRdEn is 0 exactly when register 0 bits [7:6] are nonzero and equal the 2-bit menu value.
- R11: A soft reset pulse clears the outer registers and the latch, and adds 1 (modulo 4) to the menu value. Power-on reset sets the menu value to 0.
- R12: After power-on reset all outer registers are 0, so mode A inner banking with full masks is active and romRdEn is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| softRst | input | 1 | Console reset pulse, synchronous |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| aPrgLo | input | 8 | Mode A inner bank, first switchable window |
| aPrgHi | input | 8 | Mode A inner bank, second window |
| aPrgSwap | input | 1 | Mode A window swap |
| aChr | input | 64 | Mode A eight 1 KiB inner banks, window i at [8i+7:8i] |
| aMirror | input | 2 | Mode A mirroring |
| bPrgLo | input | 8 | Mode B inner bank, first switchable window |
| bPrgHi | input | 8 | Mode B inner bank, second window |
| bPrgSwap | input | 1 | Mode B window swap |
| bChr | input | 64 | Mode B eight 1 KiB inner banks |
| bMirror | input | 2 | Mode B mirroring |
| prgBanks | output | 32 | Final 8 KiB program banks, window i at [8i+7:8i] |
| chrBanks | output | 88 | Final 1 KiB character banks, window i at [11i+10:11i] |
| mirror | output | 2 | Mirroring of the active inner mode |
| romRdEn | output | 1 | Cartridge ROM read enable |
| innerAWrStb | output | 1 | Write strobe towards inner mode A |
| innerBWrStb | output | 1 | Write strobe towards inner mode B |

## Verification
Every output here is a combinational function of the stored registers, so a wrong register, latch or menu value shows on the ports in the very next cycle. A wrong register 0 corrupts the upper bits of all four program windows. A wrong register 2 moves the mask boundary or flips the banking mode. A wrong menu value only appears once register 0 holds a matching top pair, which is why the bench steps through soft resets and probes each menu value. A misrouted upper write shows at once on the inner strobes, and one cycle later on the character banks if the latch took it.

// File: rtl/mcBankPkg.sv
package mcBankPkg;
  localparam int OUTER_REGS = 4;
  localparam logic [3:0] OUTER_PAGE = 4'h5;

  typedef struct packed {
    logic       wrOuter;
    logic [1:0] outerIdx;
    logic       wrLatch;
    logic       softClear;
  } mcStrobe_t;
endpackage

// File: rtl/mcMaskMerge.sv
module mcMaskMerge #(
  parameter int W = 8
) (
  input  logic [W-1:0] innerVal,
  input  logic [W-1:0] outerVal,
  input  logic [W-1:0] keepMask,
  output logic [W-1:0] merged
);
  always_comb merged = (innerVal & keepMask) | (outerVal & ~keepMask);
endmodule

// File: rtl/mcOuterCtrl.sv
module mcOuterCtrl import mcBankPkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int DIP_W     = 2,
  parameter int SEL_W     = 3,
  parameter int LATCH_MIN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              locked,
  input  logic              modeB,
  input  logic [SEL_W-1:0]  chrSizeSel,
  input  logic [DIP_W-1:0]  reg0Hi,
  output mcStrobe_t         stb,
  output logic              innerAWrStb,
  output logic              innerBWrStb,
  output logic              romRdEn,
  output logic [DIP_W-1:0]  dipVal
);
  logic romSpace;
  logic outerSpace;
  logic latchMode;
  logic liveWr;

  always_comb begin
    liveWr     = cpuWrEn && !softRst;
    romSpace   = cpuAddr[ADDR_W-1];
    outerSpace = (cpuAddr[ADDR_W-1 -: 4] == OUTER_PAGE);
    latchMode  = (chrSizeSel >= SEL_W'(LATCH_MIN));
  end

  always_comb begin
    stb.softClear = softRst;
    stb.wrOuter   = liveWr && outerSpace && !locked;
    stb.outerIdx  = cpuAddr[1:0];
    stb.wrLatch   = liveWr && romSpace && latchMode;
    innerAWrStb   = liveWr && romSpace && !latchMode && !modeB;
    innerBWrStb   = liveWr && romSpace && !latchMode && modeB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        dipVal <= '0;
    else if (softRst) dipVal <= dipVal + DIP_W'(1);
  end

  always_comb romRdEn = !((reg0Hi != '0) && (reg0Hi == dipVal));
endmodule

// File: rtl/mcOuterDatapath.sv
module mcOuterDatapath import mcBankPkg::*; #(
  parameter int DATA_W    = 8,
  parameter int NUM_PRG   = 4,
  parameter int NUM_CHR   = 8,
  parameter int SEL_W     = 3,
  parameter int DIP_W     = 2,
  parameter int PRG_SRC_W = 7,
  parameter int PRG_MSK_W = 5,
  parameter int CHR_SRC_W = 10,
  parameter int CHR_MSK_W = 8,
  parameter int PRG_MODE_BIT = 2,
  parameter int CHR_MODE_BIT = 5,
  parameter int LOCK_BIT  = 5,
  parameter int MODE_BIT  = 4,
  localparam int SUB_W    = $clog2(NUM_CHR),
  localparam int CHR_W    = DATA_W + SUB_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mcStrobe_t                 stb,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [DATA_W-1:0]         aPrgLo,
  input  logic [DATA_W-1:0]         aPrgHi,
  input  logic                      aPrgSwap,
  input  logic [NUM_CHR*DATA_W-1:0] aChr,
  input  logic [1:0]                aMirror,
  input  logic [DATA_W-1:0]         bPrgLo,
  input  logic [DATA_W-1:0]         bPrgHi,
  input  logic                      bPrgSwap,
  input  logic [NUM_CHR*DATA_W-1:0] bChr,
  input  logic [1:0]                bMirror,
  output logic [NUM_PRG*DATA_W-1:0] prgBanks,
  output logic [NUM_CHR*CHR_W-1:0]  chrBanks,
  output logic [1:0]                mirror,
  output logic                      locked,
  output logic                      modeB,
  output logic [SEL_W-1:0]          chrSizeSel,
  output logic [DIP_W-1:0]          reg0Hi
);
  logic [DATA_W-1:0] outerReg [OUTER_REGS];
  logic [DATA_W-1:0] latch8;
  logic [OUTER_REGS*DATA_W-1:0] outerFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < OUTER_REGS; i++) outerReg[i] <= '0;
      latch8 <= '0;
    end else if (stb.softClear) begin
      for (int i = 0; i < OUTER_REGS; i++) outerReg[i] <= '0;
      latch8 <= '0;
    end else begin
      if (stb.wrOuter) outerReg[stb.outerIdx] <= wrData;
      if (stb.wrLatch) latch8 <= wrData;
    end
  end

  for (genvar r = 0; r < OUTER_REGS; r++) begin : g_flat
    assign outerFlat[r*DATA_W +: DATA_W] = outerReg[r];
  end

  logic [SEL_W-1:0] prgSizeSel;
  always_comb begin
    prgSizeSel = outerReg[2][SEL_W-1:0];
    chrSizeSel = outerReg[2][2*SEL_W-1:SEL_W];
    locked     = outerReg[3][LOCK_BIT];
    modeB      = outerReg[3][MODE_BIT];
    reg0Hi     = outerReg[0][DATA_W-1 -: DIP_W];
  end

  // size masks
  logic [PRG_SRC_W-1:0] prgFull;
  logic [CHR_SRC_W-1:0] chrFull;
  logic [DATA_W-1:0]    prgMask;
  logic [CHR_W-1:0]     chrMask;
  logic [DATA_W-1:0]    chr8Mask;
  logic                 innerPrg;
  logic                 fineChr;

  always_comb begin
    prgFull  = {PRG_SRC_W{1'b1}} >> prgSizeSel;
    chrFull  = {CHR_SRC_W{1'b1}} >> chrSizeSel;
    prgMask  = DATA_W'(prgFull[PRG_MSK_W-1:0]);
    chrMask  = CHR_W'(chrFull[CHR_MSK_W-1:0]);
    chr8Mask = DATA_W'(chrFull[CHR_MSK_W-1:SUB_W]);
    innerPrg = prgFull[PRG_MODE_BIT];
    fineChr  = chrFull[CHR_MODE_BIT];
  end

  // active inner source
  logic [DATA_W-1:0]         selLo;
  logic [DATA_W-1:0]         selHi;
  logic                      selSwap;
  logic [NUM_CHR*DATA_W-1:0] selChr;

  always_comb begin
    selLo   = modeB ? bPrgLo   : aPrgLo;
    selHi   = modeB ? bPrgHi   : aPrgHi;
    selSwap = modeB ? bPrgSwap : aPrgSwap;
    selChr  = modeB ? bChr     : aChr;
    mirror  = modeB ? bMirror  : aMirror;
  end

  // program windows
  logic [DATA_W-1:0] prgInner [NUM_PRG];
  localparam logic [DATA_W-1:0] FIXED_LAST = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] FIXED_PREV = {{(DATA_W-1){1'b1}}, 1'b0};

  always_comb begin
    if (innerPrg) begin
      prgInner[0] = selSwap ? FIXED_PREV : selLo;
      prgInner[1] = selHi;
      prgInner[2] = selSwap ? selLo : FIXED_PREV;
      prgInner[3] = FIXED_LAST;
    end else begin
      for (int w = 0; w < NUM_PRG; w++) prgInner[w] = DATA_W'(w);
    end
  end

  for (genvar w = 0; w < NUM_PRG; w++) begin : g_prg
    mcMaskMerge #(.W(DATA_W)) u_mergePrg (
      .innerVal (prgInner[w]),
      .outerVal (outerReg[0]),
      .keepMask (prgMask),
      .merged   (prgBanks[w*DATA_W +: DATA_W])
    );
  end

  // character windows
  logic [DATA_W-1:0] bank8;
  mcMaskMerge #(.W(DATA_W)) u_merge8k (
    .innerVal (latch8),
    .outerVal (outerReg[1]),
    .keepMask (chr8Mask),
    .merged   (bank8)
  );

  logic [CHR_W-1:0] chrOuter;
  always_comb chrOuter = {outerReg[1], {SUB_W{1'b0}}};

  for (genvar c = 0; c < NUM_CHR; c++) begin : g_chr
    logic [CHR_W-1:0] fine;
    mcMaskMerge #(.W(CHR_W)) u_mergeChr (
      .innerVal (CHR_W'(selChr[c*DATA_W +: DATA_W])),
      .outerVal (chrOuter),
      .keepMask (chrMask),
      .merged   (fine)
    );
    assign chrBanks[c*CHR_W +: CHR_W] = fineChr ? fine : {bank8, SUB_W'(c)};
  end
endmodule

// File: rtl/mcOuterBankMixer.sv
module mcOuterBankMixer import mcBankPkg::*; #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_PRG = 4,
  parameter int NUM_CHR = 8
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      softRst,
  input  logic                                      cpuWrEn,
  input  logic [ADDR_W-1:0]                         cpuAddr,
  input  logic [DATA_W-1:0]                         cpuWrData,
  input  logic [DATA_W-1:0]                         aPrgLo,
  input  logic [DATA_W-1:0]                         aPrgHi,
  input  logic                                      aPrgSwap,
  input  logic [NUM_CHR*DATA_W-1:0]                 aChr,
  input  logic [1:0]                                aMirror,
  input  logic [DATA_W-1:0]                         bPrgLo,
  input  logic [DATA_W-1:0]                         bPrgHi,
  input  logic                                      bPrgSwap,
  input  logic [NUM_CHR*DATA_W-1:0]                 bChr,
  input  logic [1:0]                                bMirror,
  output logic [NUM_PRG*DATA_W-1:0]                 prgBanks,
  output logic [NUM_CHR*(DATA_W+$clog2(NUM_CHR))-1:0] chrBanks,
  output logic [1:0]                                mirror,
  output logic                                      romRdEn,
  output logic                                      innerAWrStb,
  output logic                                      innerBWrStb
);
  localparam int SEL_W = 3;
  localparam int DIP_W = 2;

  mcStrobe_t        stb;
  logic             locked;
  logic             modeB;
  logic [SEL_W-1:0] chrSizeSel;
  logic [DIP_W-1:0] reg0Hi;
  logic [DIP_W-1:0] dipVal;

  mcOuterCtrl #(.ADDR_W(ADDR_W), .DIP_W(DIP_W), .SEL_W(SEL_W)) u_ctrl (
    .clk, .rstN, .softRst, .cpuWrEn, .cpuAddr,
    .locked, .modeB, .chrSizeSel, .reg0Hi,
    .stb, .innerAWrStb, .innerBWrStb, .romRdEn, .dipVal
  );

  mcOuterDatapath #(.DATA_W(DATA_W), .NUM_PRG(NUM_PRG), .NUM_CHR(NUM_CHR),
                    .SEL_W(SEL_W), .DIP_W(DIP_W)) u_dp (
    .clk, .rstN, .stb, .wrData(cpuWrData),
    .aPrgLo, .aPrgHi, .aPrgSwap, .aChr, .aMirror,
    .bPrgLo, .bPrgHi, .bPrgSwap, .bChr, .bMirror,
    .prgBanks, .chrBanks, .mirror,
    .locked, .modeB, .chrSizeSel, .reg0Hi
  );
endmodule

// File: rtl/mcOuterBankMixer_chk.sv
module mcOuterBankMixer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        softRst,
  input logic        cpuWrEn,
  input logic [15:0] cpuAddr,
  input logic [7:0]  cpuWrData,
  input logic        romRdEn,
  input logic        innerAWrStb,
  input logic        innerBWrStb,
  input logic        locked,
  input logic [31:0] outerFlat,
  input logic [1:0]  dipVal
);
  AST_OUTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr[15:12] == 4'h5 && cpuAddr[1:0] == 2'd0 && !locked && !softRst)
    |=> (outerFlat[7:0] == $past(cpuWrData))); // R1

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !softRst) |=> $stable(outerFlat)); // R2

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (outerFlat == 32'd0)); // R11

  AST_DIP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (dipVal == 2'($past(dipVal) + 2'd1))); // R11

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({innerAWrStb, innerBWrStb})); // R8

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (innerAWrStb || innerBWrStb) |-> (cpuWrEn && cpuAddr[15])); // R8

  AST_READ_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !romRdEn |-> (outerFlat[7:6] != 2'd0)); // R10
endmodule

bind mcOuterBankMixer mcOuterBankMixer_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .softRst     (softRst),
  .cpuWrEn     (cpuWrEn),
  .cpuAddr     (cpuAddr),
  .cpuWrData   (cpuWrData),
  .romRdEn     (romRdEn),
  .innerAWrStb (innerAWrStb),
  .innerBWrStb (innerBWrStb),
  .locked      (u_dp.locked),
  .outerFlat   (u_dp.outerFlat),
  .dipVal      (u_ctrl.dipVal)
);

// File: tb/mcOuterBankMixer_bench.sv
`timescale 1ns/100ps
module mcOuterBankMixer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  aPrgLo = 8'h0B, aPrgHi = 8'h16, bPrgLo = 8'h1A, bPrgHi = 8'h05;
  logic        aPrgSwap = 1'b0, bPrgSwap = 1'b0;
  logic [63:0] aChr, bChr;
  logic [1:0]  aMirror = 2'd1, bMirror = 2'd2;
  logic [31:0] prgBanks;
  logic [87:0] chrBanks;
  logic [1:0]  mirror;
  logic        romRdEn, innerAWrStb, innerBWrStb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mcOuterBankMixer u_mcOuterBankMixer (
    .clk, .rstN, .softRst, .cpuWrEn, .cpuAddr, .cpuWrData,
    .aPrgLo, .aPrgHi, .aPrgSwap, .aChr, .aMirror,
    .bPrgLo, .bPrgHi, .bPrgSwap, .bChr, .bMirror,
    .prgBanks, .chrBanks, .mirror, .romRdEn, .innerAWrStb, .innerBWrStb
  );

  // reference model state
  int mReg[4];
  int mLatch;
  int mDip;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mReg[i]) mReg[i] = 0;
      mLatch = 0;
      mDip = 0;
    end else if (softRst) begin
      foreach (mReg[i]) mReg[i] = 0;
      mLatch = 0;
      mDip = (mDip + 1) % 4;
    end else if (cpuWrEn) begin
      if (cpuAddr[15:12] == 4'h5) begin
        if ((mReg[3] & 'h20) == 0) mReg[cpuAddr[1:0]] = int'(cpuWrData);
      end else if (cpuAddr[15] && ((mReg[2] >> 3) & 7) >= 5) begin
        mLatch = int'(cpuWrData);
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int prgOut(int w);
    return int'(prgBanks[w*8 +: 8]);
  endfunction

  function automatic int chrOut(int w);
    return int'(chrBanks[w*11 +: 11]);
  endfunction

  // compare with the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      automatic int useB = (mReg[3] >> 4) & 1;
      automatic int lo   = useB ? int'(bPrgLo) : int'(aPrgLo);
      automatic int hi   = useB ? int'(bPrgHi) : int'(aPrgHi);
      automatic int sw   = useB ? int'(bPrgSwap) : int'(aPrgSwap);
      automatic int pm   = ('h7F >> (mReg[2] & 7)) & 'h1F;
      automatic int cm   = ('h3FF >> ((mReg[2] >> 3) & 7)) & 'hFF;
      automatic int v[4];
      automatic string ptag;
      automatic int rdExp, stA, stB, hitRom;
      if ((pm & 4) != 0) begin
        v[0] = sw ? 'hFE : lo; v[1] = hi; v[2] = sw ? lo : 'hFE; v[3] = 'hFF;
        ptag = sw ? "R4" : "R3";
      end else begin
        for (int k = 0; k < 4; k++) v[k] = k;
        ptag = "R5";
      end
      for (int k = 0; k < 4; k++)
        chk(ptag, $sformatf("prg window %0d", k), prgOut(k), ((v[k] & pm) | (mReg[0] & ~pm)) & 'hFF);
      for (int k = 0; k < 8; k++) begin
        automatic int ci = useB ? int'(bChr[k*8 +: 8]) : int'(aChr[k*8 +: 8]);
        if ((cm & 'h20) != 0)
          chk("R6", $sformatf("chr window %0d", k), chrOut(k), ((ci & cm) | ((mReg[1] << 3) & ~cm)) & 'h7FF);
        else
          chk("R7", $sformatf("chr window %0d", k), chrOut(k),
              ((((mLatch & (cm >> 3)) | (mReg[1] & ~(cm >> 3))) & 'hFF) * 8) + k);
      end
      chk("R9", "mirror", int'(mirror), useB ? int'(bMirror) : int'(aMirror));
      rdExp = (((mReg[0] >> 6) & 3) != 0 && ((mReg[0] >> 6) & 3) == mDip) ? 0 : 1;
      chk("R10", "romRdEn", int'(romRdEn), rdExp);
      hitRom = (cpuWrEn && !softRst && cpuAddr[15] && ((mReg[2] >> 3) & 7) < 5) ? 1 : 0;
      stA = hitRom && !useB;
      stB = hitRom && useB;
      chk("R8", "strobe A", int'(innerAWrStb), stA);
      chk("R8", "strobe B", int'(innerBWrStb), stB);
    end
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #0.5;
    cpuWrEn = 1'b1; cpuAddr = a; cpuWrData = d;
    @(posedge clk); #0.5;
    cpuWrEn = 1'b0;
  endtask

  task automatic pulseSoft();
    @(posedge clk); #0.5;
    softRst = 1'b1;
    @(posedge clk); #0.5;
    softRst = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      aChr[i*8 +: 8] = 8'(8'h41 + i);
      bChr[i*8 +: 8] = 8'(8'hA0 + i);
    end
    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;

    // R12: power-on state
    @(negedge clk);
    chk("R12", "prg window 3 after reset", prgOut(3), 'h1F);
    chk("R12", "prg window 0 after reset", prgOut(0), 'h0B);
    chk("R12", "chr window 2 after reset", chrOut(2), 'h43);
    chk("R12", "romRdEn after reset", int'(romRdEn), 1);

    // R1, R3: outer register writes and inner banking with a 16-bank mask
    wr(16'h5000, 8'h25);
    wr(16'h5001, 8'h13);
    wr(16'h5002, 8'h1B);
    @(negedge clk);
    chk("R1", "prg window 3 after writes", prgOut(3), 'h2F);
    chk("R3", "prg window 1", prgOut(1), 'h26);
    chk("R6", "chr window 2 with 128-bank mask", chrOut(2), 'hC3);

    // R4: swap
    @(posedge clk); #0.5 aPrgSwap = 1'b1;
    @(negedge clk);
    chk("R4", "prg window 0 swapped", prgOut(0), 'h2E);
    chk("R4", "prg window 2 swapped", prgOut(2), 'h2B);

    // R5: flat banking
    wr(16'h5002, 8'h1D);
    @(negedge clk);
    chk("R5", "flat window 0", prgOut(0), 'h24);
    chk("R5", "flat window 3", prgOut(3), 'h27);

    // R7, R8: 8 KiB mode and latch routing
    wr(16'h5002, 8'h35);
    @(posedge clk); #0.5;
    cpuWrEn = 1'b1; cpuAddr = 16'h8000; cpuWrData = 8'h07;
    @(negedge clk);
    chk("R8", "no inner strobe on latch write", int'(innerAWrStb), 0);
    @(posedge clk); #0.5 cpuWrEn = 1'b0;
    @(negedge clk);
    chk("R7", "8k window 5", chrOut(5), 'h9D);
    chk("R7", "8k window 0", chrOut(0), 'h98);

    wr(16'h5002, 8'h05);
    @(posedge clk); #0.5;
    cpuWrEn = 1'b1; cpuAddr = 16'hC001; cpuWrData = 8'h11;
    @(negedge clk);
    chk("R8", "strobe A on upper write", int'(innerAWrStb), 1);
    @(posedge clk); #0.5 cpuWrEn = 1'b0;

    // R9: mode B
    wr(16'h5003, 8'h10);
    wr(16'h5002, 8'h00);
    @(negedge clk);
    chk("R9", "prg window 1 from mode B", prgOut(1), 'h25);
    chk("R9", "mirror from mode B", int'(mirror), 2);
    @(posedge clk); #0.5;
    cpuWrEn = 1'b1; cpuAddr = 16'hA000; cpuWrData = 8'h22;
    @(negedge clk);
    chk("R9", "strobe B in mode B", int'(innerBWrStb), 1);
    @(posedge clk); #0.5 cpuWrEn = 1'b0;

    // R2: lock
    wr(16'h5003, 8'h30);
    wr(16'h5000, 8'h00);
    wr(16'h5003, 8'h00);
    @(negedge clk);
    chk("R2", "register 0 kept under lock", prgOut(3), 'h3F);
    chk("R2", "register 3 kept under lock", int'(mirror), 2);

    // R11, R10: soft reset and menu compare
    pulseSoft();
    @(negedge clk);
    chk("R11", "registers cleared by soft reset", prgOut(3), 'h1F);
    chk("R11", "mode bit cleared by soft reset", int'(mirror), 1);
    wr(16'h5000, 8'h40);
    @(negedge clk);
    chk("R10", "menu 1 matches", int'(romRdEn), 0);
    wr(16'h5000, 8'h80);
    @(negedge clk);
    chk("R10", "menu 1 vs 2", int'(romRdEn), 1);
    pulseSoft();
    pulseSoft();
    wr(16'h5000, 8'hC0);
    @(negedge clk);
    chk("R10", "menu 3 matches", int'(romRdEn), 0);
    pulseSoft();
    wr(16'h5000, 8'h00);
    @(negedge clk);
    chk("R10", "zero top bits never block", int'(romRdEn), 1);
    wr(16'h5000, 8'h40);
    @(negedge clk);
    chk("R10", "menu wrapped to 0", int'(romRdEn), 1);

    // R11: power-on reset returns menu to 0
    @(posedge clk); #0.5 rstN = 1'b0;
    @(posedge clk); #0.5 rstN = 1'b1;
    pulseSoft();
    wr(16'h5000, 8'h40);
    @(negedge clk);
    chk("R11", "menu restarts after power-on", int'(romRdEn), 0);

    repeat (4) @(posedge clk);
    finish();
  end
endmodule